// File: doc/BRIEF.md
# Link Port Boot Monitor

This block is a small hardware loader that sits between a byte-wide link port and a 32-bit memory bus. A host sends command bytes. A store command carries an address and a data word, and the monitor turns it into one memory write. A fetch command carries an address. The monitor reads that word from memory and sends it back to the host as four bytes.

A store whose address field is all zeros is not written to memory. The monitor treats it as a launch: it pulses a start strobe for one cycle and presents the received data word as the entry point of the program. After a launch the monitor goes silent. It accepts no more link bytes and sends none until the next reset. Reset does not touch memory, so sending the same launch command again restarts a program that is already loaded.

Top module: `link_boot_monitor`

## Requirements
- R1: After reset the monitor waits for an opcode: `in_ready_o` is 1, and `out_valid_o`, `mem_req_o` and `start_o` are 0. A command that was only partly received before reset is dropped.
- R2: Opcode byte 0x00 followed by four address bytes and four data bytes, each field least significant byte first, causes exactly one memory access with `mem_we_o`=1 at that address with that data. Example: 00, 00 00 00 20, 78 56 34 12 writes 0x12345678 to 0x20000000.
- R3: Opcode byte 0x01 followed by four address bytes, least significant byte first, causes exactly one memory access with `mem_we_o`=0 at that address.
- R4: A fetch returns exactly four bytes on the output stream, least significant byte first, of the word on `mem_rdata_i` in the acknowledge cycle. A word of 0x12345678 is returned as 78, 56, 34, 12.
- R5: While `mem_req_o` is 1 and `mem_ack_i` is 0, the request, address, write enable and write data stay unchanged in the next cycle.
- R6: An output byte is held on `out_data_o` with `out_valid_o` high until `out_ready_i` is seen. While a reply is being sent, `in_ready_o` is 0.
- R7: A store to address 0x00000000 issues no memory access. It raises `start_o` for exactly one cycle, with `start_addr_o` equal to the received data word.
- R8: After `start_o` has pulsed, `in_ready_o`, `out_valid_o` and `mem_req_o` stay 0 until reset.
- R9: Reset issues no memory access. After reset, sending the same launch command pulses `start_o` again with the same entry address.
- R10: An opcode byte other than 0x00 or 0x01 is consumed and dropped, and the next byte is taken as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte is valid |
| in_data_i | input | 8 | Input command byte |
| in_ready_o | output | 1 | Monitor takes the input byte at this edge |
| out_valid_o | output | 1 | Reply byte is valid |
| out_data_o | output | 8 | Reply byte |
| out_ready_i | input | 1 | Receiver takes the reply byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 32 | Read data, valid together with acknowledge |
| start_o | output | 1 | One-cycle launch strobe |
| start_addr_o | output | 32 | Program entry address, valid with `start_o` |

## Verification
The bench runs a mix of stores and fetches on a memory model whose acknowledge latency changes from one access to the next. Addresses and data use distinct byte values, so a byte-order mistake in assembling a field or in sending a reply gives a wrong value rather than one that happens to match. A fetch with a stalled receiver shows whether reply bytes are held and whether input stays blocked meanwhile. Junk opcodes, a reset in the middle of a command, and launch, silence and relaunch sequences each test one control path that ordinary traffic never takes.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_STORE = 8'h00;
  localparam logic [BYTE_W-1:0] OPC_FETCH = 8'h01;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_MEM,
    ST_REPLY,
    ST_HALT
  } bm_state_e;
endpackage

// File: rtl/bm_field_shift.sv
// Gathers NBYTES bytes, least significant first, into one word.
module bm_field_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 4,
  localparam int unsigned W = BYTE_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [W-1:0]      word_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= {byte_i, word_q[W-1:BYTE_W]};
  end

  assign word_o = word_q;
endmodule

// File: rtl/bm_reply_ser.sv
// Holds a fetched word and sends it out one byte at a time, least significant byte first.
module bm_reply_ser #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 4,
  localparam int unsigned W = BYTE_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [W-1:0]      word_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
    else if (pop_i)  word_q <= {{BYTE_W{1'b0}}, word_q[W-1:BYTE_W]};
  end

  assign byte_o = word_q[BYTE_W-1:0];
endmodule

// File: rtl/link_boot_monitor.sv
module link_boot_monitor
  import bm_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned W     = BYTE_W * NBYTES,
  localparam int unsigned CNT_W = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [W-1:0]      mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [W-1:0]      mem_rdata_i,
  output logic              start_o,
  output logic [W-1:0]      start_addr_o
);
  bm_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             store_q;
  logic             start_q;
  logic [W-1:0]     addr_w, data_w;
  logic             in_fire, out_fire, last_byte;
  logic             addr_shift, data_shift, launch;

  assign in_ready_o  = (state_q == ST_OPC) || (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign out_valid_o = (state_q == ST_REPLY);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign last_byte   = (cnt_q == CNT_W'(NBYTES - 1));
  assign addr_shift  = in_fire && (state_q == ST_ADDR);
  assign data_shift  = in_fire && (state_q == ST_DATA);
  // a store to address zero hands over control instead of writing
  assign launch      = data_shift && last_byte && (addr_w == '0);

  bm_field_shift #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_addr_field (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(addr_shift),
    .byte_i (in_data_i),
    .word_o (addr_w)
  );

  bm_field_shift #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_data_field (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(data_shift),
    .byte_i (in_data_i),
    .word_o (data_w)
  );

  bm_reply_ser #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_reply (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_MEM && mem_ack_i && !store_q),
    .word_i (mem_rdata_i),
    .pop_i  (out_fire),
    .byte_o (out_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPC:   if (in_fire && (in_data_i == OPC_STORE || in_data_i == OPC_FETCH)) state_d = ST_ADDR;
      ST_ADDR:  if (in_fire && last_byte) state_d = store_q ? ST_DATA : ST_MEM;
      ST_DATA:  if (in_fire && last_byte) state_d = launch ? ST_HALT : ST_MEM;
      ST_MEM:   if (mem_ack_i) state_d = store_q ? ST_OPC : ST_REPLY;
      ST_REPLY: if (out_fire && last_byte) state_d = ST_OPC;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_OPC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      store_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= launch;
      if (state_q == ST_OPC && in_fire) store_q <= (in_data_i == OPC_STORE);
      if (addr_shift || data_shift || out_fire)
        cnt_q <= last_byte ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign mem_req_o    = (state_q == ST_MEM);
  assign mem_we_o     = store_q;
  assign mem_addr_o   = addr_w;
  assign mem_wdata_o  = data_w;
  assign start_o      = start_q;
  assign start_addr_o = data_w;

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R6
  no_input_in_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  // R7
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R7
  start_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !mem_req_o && $past(in_fire));
  // R8
  silent_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !in_ready_o && !out_valid_o && !mem_req_o);
endmodule

// File: tb/link_boot_monitor_bench.sv
`timescale 1ns/1ps
module link_boot_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        start;
  logic [31:0] start_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  link_boot_monitor u_link_boot_monitor (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .start_o(start), .start_addr_o(start_addr)
  );

  // memory model, contents survive reset
  logic [31:0] mem [16];
  int lat = 0;
  int wait_cnt = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [31:0] last_wa = '0, last_wd = '0, last_ra = '0;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem_ack = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat) begin
        mem_ack  <= 1'b1;
        wait_cnt <= 0;
        if (mem_we) begin
          mem[mem_addr[5:2]] <= mem_wdata;
          wr_cnt  <= wr_cnt + 1;
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[5:2]];
          rd_cnt  <= rd_cnt + 1;
          last_ra <= mem_addr;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // start strobe monitor
  int start_cnt = 0;
  int start_run = 0;
  int start_maxw = 0;
  logic [31:0] start_cap = '0;
  always @(negedge clk) begin
    if (start) begin
      start_cnt <= start_cnt + 1;
      start_cap <= start_addr;
      start_run <= start_run + 1;
      if (start_run + 1 > start_maxw) start_maxw <= start_run + 1;
    end else begin
      start_run <= 0;
    end
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    int guard = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) send_byte(w[k*8 +: 8]);
  endtask

  task automatic send_store(input logic [31:0] a, input logic [31:0] d);
    send_byte(8'h00);
    send_word(a);
    send_word(d);
  endtask

  task automatic send_fetch(input logic [31:0] a);
    send_byte(8'h01);
    send_word(a);
  endtask

  task automatic recv_word(input int stall, output logic [31:0] w);
    int guard;
    logic [7:0] b;
    int bad;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      guard = 0;
      while (!out_valid && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      b = out_data;
      bad = 0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (!out_valid || out_data !== b || in_ready) bad++;
      end
      if (stall > 0) check_eq("R6 byte held, input blocked", 32'(bad), 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      w[k*8 +: 8] = b;
    end
  endtask

  task automatic wait_store(input int prev, input logic [31:0] a, input logic [31:0] d);
    int guard = 0;
    int bad = 0;
    while (wr_cnt == prev && guard < 1000) begin
      @(negedge clk);
      if (mem_req && (mem_addr !== a || mem_wdata !== d || mem_we !== 1'b1)) bad++;
      guard++;
    end
    check_eq("R5 request stable", 32'(bad), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {is_fetch, address, data or expected word}
  localparam logic [64:0] VEC [8] = '{
    {1'b0, 32'h2000_0000, 32'h1234_5678},
    {1'b1, 32'h2000_0000, 32'h1234_5678},
    {1'b0, 32'h2000_0004, 32'hA5A5_0F0F},
    {1'b0, 32'h0000_003C, 32'hDEAD_BEEF},
    {1'b1, 32'h0000_003C, 32'hDEAD_BEEF},
    {1'b1, 32'h2000_0004, 32'hA5A5_0F0F},
    {1'b0, 32'h8000_0010, 32'h0000_0001},
    {1'b1, 32'h8000_0010, 32'h0000_0001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int wc, rc, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 in_ready", 32'(in_ready), 32'd1);
    check_eq("R1 out_valid", 32'(out_valid), 32'd0);
    check_eq("R1 mem_req", 32'(mem_req), 32'd0);
    check_eq("R1 start", 32'(start), 32'd0);

    for (int i = 0; i < 8; i++) begin
      lat = i % 3;
      if (!VEC[i][64]) begin
        wc = wr_cnt;
        send_store(VEC[i][63:32], VEC[i][31:0]);
        wait_store(wc, VEC[i][63:32], VEC[i][31:0]);
        check_eq("R2 store count", 32'(wr_cnt - wc), 32'd1);
        check_eq("R2 store address", last_wa, VEC[i][63:32]);
        check_eq("R2 store data", last_wd, VEC[i][31:0]);
      end else begin
        rc = rd_cnt;
        send_fetch(VEC[i][63:32]);
        recv_word(0, w);
        check_eq("R3 fetch count", 32'(rd_cnt - rc), 32'd1);
        check_eq("R3 fetch address", last_ra, VEC[i][63:32]);
        check_eq("R4 reply word", w, VEC[i][31:0]);
      end
    end

    // R10 junk opcodes dropped
    wc = wr_cnt; rc = rd_cnt;
    send_byte(8'h07);
    send_byte(8'hFF);
    @(negedge clk);
    check_eq("R10 ready after junk", 32'(in_ready), 32'd1);
    send_fetch(32'h2000_0000);
    recv_word(0, w);
    check_eq("R10 fetch after junk", w, 32'h1234_5678);
    check_eq("R10 no store", 32'(wr_cnt - wc), 32'd0);
    check_eq("R10 one fetch", 32'(rd_cnt - rc), 32'd1);

    // R6 stalled receiver, R4 byte order
    lat = 2;
    send_fetch(32'h0000_003C);
    recv_word(3, w);
    check_eq("R6 R4 stalled reply", w, 32'hDEAD_BEEF);

    // R1 partial command dropped by reset
    wc = wr_cnt;
    send_byte(8'h00);
    send_byte(8'h11);
    send_byte(8'h22);
    do_reset();
    @(negedge clk);
    check_eq("R1 ready after mid reset", 32'(in_ready), 32'd1);
    send_fetch(32'h2000_0004);
    recv_word(0, w);
    check_eq("R1 clean fetch after reset", w, 32'hA5A5_0F0F);
    check_eq("R1 no store from partial", 32'(wr_cnt - wc), 32'd0);

    // R7 launch
    wc = wr_cnt; rc = rd_cnt;
    send_store(32'h0000_0000, 32'h2000_0000);
    repeat (4) @(negedge clk);
    check_eq("R7 start count", 32'(start_cnt), 32'd1);
    check_eq("R7 start width", 32'(start_maxw), 32'd1);
    check_eq("R7 entry address", start_cap, 32'h2000_0000);
    check_eq("R7 no memory access", 32'(wr_cnt - wc + rd_cnt - rc), 32'd0);

    // R8 silence
    bad = 0;
    in_valid = 1'b1;
    in_data = 8'h01;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (in_ready || out_valid || mem_req) bad++;
    end
    in_valid = 1'b0;
    check_eq("R8 silent after start", 32'(bad), 32'd0);
    check_eq("R8 start stays single", 32'(start_cnt), 32'd1);

    // R9 reset keeps memory, relaunch
    wc = wr_cnt; rc = rd_cnt;
    do_reset();
    repeat (3) @(negedge clk);
    check_eq("R9 no access on reset", 32'(wr_cnt - wc + rd_cnt - rc), 32'd0);
    send_fetch(32'h2000_0000);
    recv_word(0, w);
    check_eq("R9 program word kept", w, 32'h1234_5678);
    send_store(32'h0000_0000, 32'h2000_0000);
    repeat (4) @(negedge clk);
    check_eq("R9 relaunch count", 32'(start_cnt), 32'd2);
    check_eq("R9 relaunch address", start_cap, 32'h2000_0000);
    check_eq("R9 relaunch width", 32'(start_maxw), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule